// File: doc/BRIEF.md
# Two-List Replacement Translation Buffer

A fully associative address translation buffer whose entries sit in two equal pools, an active list and an inactive list. Each pool is a ring with its own head and tail pointer, so its entries stay in arrival order. Each lookup searches both pools at once and answers one cycle later with a hit flag and a physical page number. A miss raises a refill request that an external page walker serves by writing the translation back through the refill port. Pages are 4 KiB, virtual addresses are 48 bits (36-bit page number) and physical addresses are 39 bits (27-bit page number).

Replacement is done by moving entries between the lists, not by tracking recency per entry. A refill always lands at the active tail. A full active list pushes its oldest entry to the inactive tail. A full inactive list drops its oldest entry first. A hit in the inactive list pulls that entry back to the active tail and leaves an invalid hole in the inactive ring, which the head pointer later steps over. In cycles with no traffic, the inactive list sheds its oldest entry while its occupancy is above a programmable threshold. This keeps the lists from filling completely. A synchronous invalidate-all clears the structure in one cycle.

Top module: `twolist_tlb`

## Requirements
- R1: A lookup accepted in cycle t (request valid, no invalidate-all) gives exactly one response, with resp_valid high in cycle t+1 only.
- R2: A hit drives resp_hit=1 and the stored physical page number, with miss_req=0. A miss drives resp_hit=0 and miss_req=1 in the same cycle, and miss_vpn equals the looked-up page number.
- R3: A refill whose page number matches no valid entry is placed at the tail of the active list. A later lookup of it hits.
- R4: A refill into a full active list first moves the oldest active entry to the inactive tail. That entry stays reachable by lookup.
- R5: A refill when both lists are full does three things in order: it drops the oldest inactive entry, moves the oldest active entry to the inactive tail, then inserts the new one. Neither list ever holds more valid entries than its pool depth.
- R6: A lookup that hits in the inactive list moves that entry to the active tail. This uses the same cascade as a refill. The slot the entry leaves is marked invalid, and the inactive head steps over invalid slots.
- R7: A refill whose page number is already held updates that entry's physical page number in place and adds no second copy.
- R8: In a cycle with no lookup, no refill and no invalidate-all, the oldest inactive entry is dropped if the inactive occupancy is strictly greater than idle_thresh. Otherwise nothing is dropped.
- R9: The invalidate-all input empties both lists in one cycle. A lookup in that cycle gets no response, and refills after it work normally.
- R10: When a lookup and a refill come in the same cycle, the lookup is answered from the contents as they were before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous invalidate-all |
| req_valid | input | 1 | Lookup request strobe |
| req_vpn | input | VPN_W (36) | Virtual page number to translate |
| fill_valid | input | 1 | Refill write strobe from the page walker |
| fill_vpn | input | VPN_W (36) | Virtual page number of the refill |
| fill_ppn | input | PPN_W (27) | Physical page number of the refill |
| idle_thresh | input | CNT_W (7) | Inactive occupancy above which idle cycles drop entries |
| resp_valid | output | 1 | Lookup response strobe |
| resp_hit | output | 1 | Response is a hit |
| resp_ppn | output | PPN_W (27) | Translated physical page number |
| miss_req | output | 1 | Refill request to the page walker |
| miss_vpn | output | VPN_W (36) | Page number the walker must fetch |

## Verification
The bound checker watches several things on every cycle. It checks the one-cycle response timing and that a miss always comes with a refill request for the right page number. It checks that both occupancy counts stay within the pool depth and are empty right after invalidate-all. It also checks that idle cycles above threshold never grow the inactive list. The order of the list movements is not visible to a single-cycle property: demotion, the order of the cascade on a double-full refill, promotion out of the inactive list, in-place update, and threshold discards. The bench shows these by filling a small four-entry configuration along chosen sequences. It then looks for which page numbers still hit or now miss.

// File: rtl/twolist_tlb_pkg.sv
package twolist_tlb_pkg;
   localparam int TLB_VA_W       = 48;
   localparam int TLB_PA_W       = 39;
   localparam int TLB_PAGE_SHIFT = 12;

   // Where a lookup found its translation
   typedef enum logic [1:0] {
      SRC_NONE     = 2'd0,
      SRC_ACTIVE   = 2'd1,
      SRC_INACTIVE = 2'd2
   } hit_src_e;
endpackage

// File: rtl/twolist_tlb_pool.sv
// One ring-ordered pool of fully associative entries with two search keys.
module twolist_tlb_pool #(
   parameter int DEPTH = 64,
   parameter int VPN_W = 36,
   parameter int PPN_W = 27,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PTR_W = IDX_W + 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] key_a,
   output logic             hit_a,
   output logic [IDX_W-1:0] idx_a,
   output logic [PPN_W-1:0] ppn_a,
   input  logic [VPN_W-1:0] key_b,
   output logic             hit_b,
   output logic [IDX_W-1:0] idx_b,
   input  logic             push_en,
   input  logic [VPN_W-1:0] push_vpn,
   input  logic [PPN_W-1:0] push_ppn,
   input  logic             pop_en,
   input  logic             inv_en,
   input  logic [IDX_W-1:0] inv_idx,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic [PPN_W-1:0] upd_ppn,
   output logic             full,
   output logic [CNT_W-1:0] count,
   output logic [VPN_W-1:0] head_vpn,
   output logic [PPN_W-1:0] head_ppn
);
   logic [VPN_W-1:0] vpn_q [DEPTH];
   logic [PPN_W-1:0] ppn_q [DEPTH];
   logic [DEPTH-1:0] vld_q;
   logic [PTR_W-1:0] head_q, tail_q, used;
   logic [CNT_W-1:0] count_q;
   logic [DEPTH-1:0] mt_a, mt_b;
   logic [IDX_W-1:0] hi, ti;
   logic             skip, pop_live;

   // Parallel tag compare, one comparator pair per slot
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign mt_a[g] = vld_q[g] && (vpn_q[g] == key_a);
      assign mt_b[g] = vld_q[g] && (vpn_q[g] == key_b);
   end

   always_comb begin
      idx_a = '0;
      idx_b = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (mt_a[i]) idx_a = IDX_W'(i);
         if (mt_b[i]) idx_b = IDX_W'(i);
      end
   end

   assign hit_a    = |mt_a;
   assign hit_b    = |mt_b;
   assign ppn_a    = ppn_q[idx_a];
   assign hi       = head_q[IDX_W-1:0];
   assign ti       = tail_q[IDX_W-1:0];
   assign used     = tail_q - head_q;
   assign full     = used[PTR_W-1];
   assign count    = count_q;
   assign head_vpn = vpn_q[hi];
   assign head_ppn = ppn_q[hi];
   // An invalid hole at the head is reclaimed in any cycle without a pop
   assign skip     = !pop_en && (used != '0) && !vld_q[hi];
   assign pop_live = pop_en && vld_q[hi] && !(inv_en && (inv_idx == hi));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         vld_q   <= '0;
         count_q <= '0;
      end else if (flush) begin
         head_q  <= '0;
         tail_q  <= '0;
         vld_q   <= '0;
         count_q <= '0;
      end else begin
         if (pop_en) begin
            vld_q[hi] <= 1'b0;
            head_q    <= head_q + 1'b1;
         end else if (skip) begin
            head_q    <= head_q + 1'b1;
         end
         if (inv_en) vld_q[inv_idx] <= 1'b0;
         if (push_en) begin
            vld_q[ti] <= 1'b1;
            tail_q    <= tail_q + 1'b1;
         end
         count_q <= count_q + CNT_W'(push_en) - CNT_W'(inv_en) - CNT_W'(pop_live);
      end
   end

   always_ff @(posedge clk) begin
      if (push_en) begin
         vpn_q[ti] <= push_vpn;
         ppn_q[ti] <= push_ppn;
      end
      if (upd_en) ppn_q[upd_idx] <= upd_ppn;
   end
endmodule

// File: rtl/twolist_tlb.sv
module twolist_tlb
   import twolist_tlb_pkg::*;
#(
   parameter int POOL_DEPTH = 64,
   parameter int VA_W       = TLB_VA_W,
   parameter int PA_W       = TLB_PA_W,
   parameter int PAGE_SHIFT = TLB_PAGE_SHIFT,
   localparam int VPN_W = VA_W - PAGE_SHIFT,
   localparam int PPN_W = PA_W - PAGE_SHIFT,
   localparam int IDX_W = $clog2(POOL_DEPTH),
   localparam int CNT_W = $clog2(POOL_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             req_valid,
   input  logic [VPN_W-1:0] req_vpn,
   input  logic             fill_valid,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic [CNT_W-1:0] idle_thresh,
   output logic             resp_valid,
   output logic             resp_hit,
   output logic [PPN_W-1:0] resp_ppn,
   output logic             miss_req,
   output logic [VPN_W-1:0] miss_vpn
);
   if (POOL_DEPTH < 2 || (1 << IDX_W) != POOL_DEPTH)
      $error("POOL_DEPTH must be a power of two of at least 2");
   if (VA_W <= PAGE_SHIFT || PA_W <= PAGE_SHIFT)
      $error("address widths must exceed the page offset");

   logic             lk, fl, idle;
   logic             a_hit_a, a_hit_b, i_hit_a, i_hit_b;
   logic [IDX_W-1:0] a_idx_unused, a_idx_b, i_idx_a, i_idx_b;
   logic [PPN_W-1:0] a_ppn_a, i_ppn_a;
   logic             act_full, in_full;
   logic [CNT_W-1:0] act_cnt, in_cnt;
   logic [VPN_W-1:0] act_head_vpn, unused_in_head_vpn;
   logic [PPN_W-1:0] act_head_ppn, unused_in_head_ppn;
   hit_src_e         src;
   logic             promote, fill_dup, ins, act_pop, in_pop;
   logic [VPN_W-1:0] ins_vpn;
   logic [PPN_W-1:0] ins_ppn;

   assign lk   = req_valid && !flush;
   assign fl   = fill_valid && !flush;
   assign idle = !req_valid && !fill_valid && !flush;

   always_comb begin
      if (a_hit_a)      src = SRC_ACTIVE;
      else if (i_hit_a) src = SRC_INACTIVE;
      else              src = SRC_NONE;
   end

   // Promotion is suppressed while a refill owns the active tail
   assign promote  = lk && !fl && (src == SRC_INACTIVE);
   assign fill_dup = a_hit_b || i_hit_b;
   assign ins      = (fl && !fill_dup) || promote;
   assign ins_vpn  = fl ? fill_vpn : req_vpn;
   assign ins_ppn  = fl ? fill_ppn : i_ppn_a;
   assign act_pop  = ins && act_full;
   assign in_pop   = (act_pop && in_full) || (idle && (in_cnt > idle_thresh));

   twolist_tlb_pool #(.DEPTH(POOL_DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_act (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .key_a(req_vpn), .hit_a(a_hit_a), .idx_a(a_idx_unused), .ppn_a(a_ppn_a),
      .key_b(fill_vpn), .hit_b(a_hit_b), .idx_b(a_idx_b),
      .push_en(ins), .push_vpn(ins_vpn), .push_ppn(ins_ppn),
      .pop_en(act_pop), .inv_en(1'b0), .inv_idx('0),
      .upd_en(fl && a_hit_b), .upd_idx(a_idx_b), .upd_ppn(fill_ppn),
      .full(act_full), .count(act_cnt),
      .head_vpn(act_head_vpn), .head_ppn(act_head_ppn)
   );

   twolist_tlb_pool #(.DEPTH(POOL_DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_inact (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .key_a(req_vpn), .hit_a(i_hit_a), .idx_a(i_idx_a), .ppn_a(i_ppn_a),
      .key_b(fill_vpn), .hit_b(i_hit_b), .idx_b(i_idx_b),
      .push_en(act_pop), .push_vpn(act_head_vpn), .push_ppn(act_head_ppn),
      .pop_en(in_pop), .inv_en(promote), .inv_idx(i_idx_a),
      .upd_en(fl && i_hit_b && !a_hit_b), .upd_idx(i_idx_b), .upd_ppn(fill_ppn),
      .full(in_full), .count(in_cnt),
      .head_vpn(unused_in_head_vpn), .head_ppn(unused_in_head_ppn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_ppn   <= '0;
         miss_req   <= 1'b0;
         miss_vpn   <= '0;
      end else begin
         resp_valid <= lk;
         resp_hit   <= lk && (src != SRC_NONE);
         resp_ppn   <= (src == SRC_ACTIVE) ? a_ppn_a : i_ppn_a;
         miss_req   <= lk && (src == SRC_NONE);
         miss_vpn   <= req_vpn;
      end
   end
endmodule

// File: rtl/twolist_tlb_chk.sv
module twolist_tlb_chk #(
   parameter int DEPTH = 64,
   parameter int VPN_W = 36,
   parameter int CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             req_valid,
   input logic [VPN_W-1:0] req_vpn,
   input logic             fill_valid,
   input logic [CNT_W-1:0] idle_thresh,
   input logic             resp_valid,
   input logic             resp_hit,
   input logic             miss_req,
   input logic [VPN_W-1:0] miss_vpn,
   input logic [CNT_W-1:0] act_cnt,
   input logic [CNT_W-1:0] in_cnt
);
   logic idle;
   assign idle = !req_valid && !fill_valid && !flush;

   AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !flush) |=> resp_valid);                              // R1
   AST_RESP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !flush) |=> !resp_valid);                            // R1
   AST_MISS_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_hit) |-> miss_req);                            // R2
   AST_MISS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      miss_req |-> (resp_valid && !resp_hit));                            // R2
   AST_MISS_VPN: assert property (@(posedge clk) disable iff (!rst_n)
      miss_req |-> (miss_vpn == $past(req_vpn)));                         // R2
   AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !flush) |=> (act_cnt != '0));                        // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (act_cnt <= CNT_W'(DEPTH)) && (in_cnt <= CNT_W'(DEPTH)));           // R5
   AST_IDLE_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && (in_cnt > idle_thresh)) |=> (in_cnt <= $past(in_cnt)));    // R8
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (act_cnt == '0 && in_cnt == '0));                         // R9
endmodule

bind twolist_tlb twolist_tlb_chk #(
   .DEPTH(POOL_DEPTH), .VPN_W(VPN_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
   .req_vpn(req_vpn), .fill_valid(fill_valid), .idle_thresh(idle_thresh),
   .resp_valid(resp_valid), .resp_hit(resp_hit), .miss_req(miss_req),
   .miss_vpn(miss_vpn), .act_cnt(act_cnt), .in_cnt(in_cnt)
);

// File: tb/tb_twolist_tlb.sv
module tb_twolist_tlb;
   localparam int D = 4;
   localparam int VW = 36;
   localparam int PW = 27;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          req_valid = 1'b0;
   logic [VW-1:0] req_vpn = '0;
   logic          fill_valid = 1'b0;
   logic [VW-1:0] fill_vpn = '0;
   logic [PW-1:0] fill_ppn = '0;
   logic [CW-1:0] idle_thresh = CW'(D);
   logic          resp_valid, resp_hit, miss_req;
   logic [PW-1:0] resp_ppn;
   logic [VW-1:0] miss_vpn;
   int            checks = 0;
   int            fails = 0;
   bit            done = 1'b0;

   always #4 clk = ~clk;

   twolist_tlb #(.POOL_DEPTH(D)) dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .req_valid(req_valid), .req_vpn(req_vpn),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .idle_thresh(idle_thresh),
      .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_ppn(resp_ppn),
      .miss_req(miss_req), .miss_vpn(miss_vpn)
   );

   function automatic logic [VW-1:0] vp(int k);
      return {4'hA, 32'(k * 7919 + 3)};
   endfunction
   function automatic logic [PW-1:0] pp(int k);
      return PW'(k * 1031 + 77);
   endfunction

   task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic do_fill(int k, logic [PW-1:0] p);
      @(negedge clk);
      fill_valid = 1'b1; fill_vpn = vp(k); fill_ppn = p;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic do_look(int k, bit exp_hit, logic [PW-1:0] exp_ppn, string rq);
      @(negedge clk);
      req_valid = 1'b1; req_vpn = vp(k);
      @(negedge clk);
      req_valid = 1'b0;
      chk(resp_valid == 1'b1, {rq, " R1 resp_valid"}, 64'(resp_valid), 64'd1);
      chk(resp_hit == exp_hit, {rq, " hit"}, 64'(resp_hit), 64'(exp_hit));
      chk(miss_req == !exp_hit, {rq, " R2 miss_req"}, 64'(miss_req), 64'(!exp_hit));
      if (exp_hit)
         chk(resp_ppn == exp_ppn, {rq, " ppn"}, 64'(resp_ppn), 64'(exp_ppn));
      else
         chk(miss_vpn == vp(k), {rq, " R2 miss_vpn"}, 64'(miss_vpn), 64'(vp(k)));
      @(negedge clk);
      chk(resp_valid == 1'b0, {rq, " R1 single response"}, 64'(resp_valid), 64'd0);
   endtask

   task automatic t_reset();
      chk(resp_valid == 1'b0, "R1 reset resp_valid", 64'(resp_valid), 64'd0);
      chk(miss_req == 1'b0, "R2 reset miss_req", 64'(miss_req), 64'd0);
      do_look(1, 1'b0, '0, "R2 empty lookup");
   endtask

   task automatic t_basic();
      do_flush();
      do_look(1, 1'b0, '0, "R2 miss before refill");
      do_fill(1, pp(1));
      do_look(1, 1'b1, pp(1), "R3 hit after refill");
   endtask

   task automatic t_demote();
      do_flush();
      for (int k = 1; k <= 5; k++) do_fill(k, pp(k));
      for (int k = 1; k <= 5; k++) do_look(k, 1'b1, pp(k), "R4 demoted still reachable");
   endtask

   task automatic t_both_full();
      do_flush();
      for (int k = 1; k <= 9; k++) do_fill(k, pp(k));
      do_look(1, 1'b0, '0, "R5 oldest inactive dropped");
      do_look(9, 1'b1, pp(9), "R5 new entry inserted");
      do_look(8, 1'b1, pp(8), "R5 active kept");
      do_look(5, 1'b1, pp(5), "R5 active head demoted not dropped");
   endtask

   task automatic t_promote();
      do_flush();
      for (int k = 1; k <= 5; k++) do_fill(k, pp(k));
      do_look(1, 1'b1, pp(1), "R6 inactive hit");
      for (int k = 6; k <= 9; k++) do_fill(k, pp(k));
      do_look(2, 1'b0, '0, "R6 pushed out by promoted entry");
      do_look(1, 1'b1, pp(1), "R6 promoted entry survives");
   endtask

   task automatic t_dup();
      do_flush();
      do_fill(1, pp(1));
      for (int k = 2; k <= 4; k++) do_fill(k, pp(k));
      do_fill(1, pp(1) ^ PW'(1));
      do_look(1, 1'b1, pp(1) ^ PW'(1), "R7 updated in place");
      for (int k = 5; k <= 9; k++) do_fill(k, pp(k));
      do_look(1, 1'b0, '0, "R7 no duplicate copy");
      do_look(2, 1'b1, pp(2), "R7 neighbour kept");
   endtask

   task automatic t_idle();
      do_flush();
      idle_thresh = CW'(1);
      for (int k = 1; k <= 6; k++) do_fill(k, pp(k));
      do_look(1, 1'b0, '0, "R8 idle drop above threshold");
      do_look(2, 1'b1, pp(2), "R8 no drop at threshold");
      idle_thresh = CW'(D);
   endtask

   task automatic t_flush();
      do_flush();
      do_fill(1, pp(1));
      do_fill(2, pp(2));
      @(negedge clk);
      flush = 1'b1; req_valid = 1'b1; req_vpn = vp(1);
      @(negedge clk);
      flush = 1'b0; req_valid = 1'b0;
      chk(resp_valid == 1'b0, "R9 no response in flush cycle", 64'(resp_valid), 64'd0);
      do_look(1, 1'b0, '0, "R9 cleared");
      do_look(2, 1'b0, '0, "R9 cleared");
      do_fill(3, pp(3));
      do_look(3, 1'b1, pp(3), "R9 refill after flush");
   endtask

   task automatic t_same();
      do_flush();
      @(negedge clk);
      req_valid = 1'b1; req_vpn = vp(7);
      fill_valid = 1'b1; fill_vpn = vp(7); fill_ppn = pp(7);
      @(negedge clk);
      req_valid = 1'b0; fill_valid = 1'b0;
      chk(resp_valid && !resp_hit, "R10 lookup sees old contents", 64'(resp_hit), 64'd0);
      chk(miss_req == 1'b1, "R10 miss_req", 64'(miss_req), 64'd1);
      do_look(7, 1'b1, pp(7), "R10 refill landed");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_demote();
      t_both_full();
      t_promote();
      t_dup();
      t_idle();
      t_flush();
      t_same();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule